// File: doc/BRIEF.md
# Byte/Word Configurable One-Time-Programmable ROM Read Port

This block is a clocked model of a one-time-programmable memory array, seen from its read side. Each location stores a 16-bit word. A width-select input switches between word reads, which drive all sixteen data lines, and byte reads. In a byte read the topmost data line stops being an output and becomes the lowest address bit, `half_sel`, which picks one half of the stored word. The array depth is set by a parameter. The full device holds one million words, and simulation uses a much smaller default.

Two separate controls gate the outputs. Chip-enable selects the device, and while it is low the port is in standby with every output lane released. Output-enable gates the drivers of a selected device. Data becomes valid a fixed number of cycles after chip-enable is applied with a steady address, and a shorter number of cycles after output-enable is applied. An identifier mode returns a fixed manufacturer code and a fixed device code in place of array data.

A programming port writes to the array, and a write can only clear bits. A separate erase input returns the whole array to all ones. Reset does the same, which represents the device as delivered.

Top module: `otp_rom_port`

## Requirements
- R1: With `wide_mode`=1, `id_mode`=0 and `data_valid`=1, `data_out` equals the full 16-bit word stored at `addr`. Both lanes of `lane_oe` are 1 (bit 0 covers `data_out[7:0]`, bit 1 covers `data_out[15:8]`).
- R2: With `wide_mode`=0, `lane_oe[1]` is 0 and `data_out[15:8]` is 0. With `half_sel`=0, `data_out[7:0]` is bits 7:0 of the stored word, and with `half_sel`=1 it is bits 15:8.
- R3: A lane is driven only while `chip_en` and `out_en` are both 1. With both at 1, `lane_oe[0]` is 1.
- R4: While `chip_en` is 0, `standby` is 1 and `lane_oe` is 0, whatever the level of `out_en`.
- R5: After reset, and in the cycle after `erase` is sampled at 1, every location reads 16'hFFFF. Erase takes priority over a program write in the same cycle.
- R6: A program write with `prog_we`=1 stores the bitwise AND of the old word and `prog_data`, so it can only clear bits.
- R7: With `id_mode`=1, the low byte is 8'h20 when `addr[0]`=0 and 8'hB1 when `addr[0]`=1. Bits 15:8 are 0 in both cases.
- R8: `data_valid` rises only after `chip_en` has been 1 for CE_LAT consecutive sampled cycles with an unchanged read key. The key is `addr`, `wide_mode`, `id_mode`, and also `half_sel` when `wide_mode` is 0. Any change of the key restarts the count.
- R9: `data_valid` also requires that `out_en` has been 1 for OE_LAT consecutive sampled cycles.
- R10: While `data_valid` is 0, `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets the array to all ones |
| chip_en | input | 1 | Device select; when low the port is in standby |
| out_en | input | 1 | Output drive gate |
| wide_mode | input | 1 | 1 = 16-bit word reads, 0 = 8-bit byte reads |
| id_mode | input | 1 | Returns identifier codes instead of array data |
| half_sel | input | 1 | Byte-mode low address bit, carried on the topmost data line |
| addr | input | ADDR_W | Word address |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | ADDR_W | Program write address |
| prog_data | input | 16 | Program data; ANDed into the stored word |
| erase | input | 1 | Sets every location to all ones |
| data_out | output | 16 | Read data |
| lane_oe | output | 2 | Drive enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |
| data_valid | output | 1 | Read data valid |
| standby | output | 1 | High while the device is deselected |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle. These are: the port stays quiet in standby, lanes are driven only under both enables, the upper lane is released in byte mode, the identifier upper byte is zero, and data is zero while not valid. They also check that valid data always follows a cycle with both enables high, and that a steady read never turns a 0 into a 1 unless an erase occurred. Exact data values need the bench's model of the array contents and its latency counters. These values are the byte-half selection, the AND result of repeated program writes, the identifier codes, erase priority, and the precise cycle at which valid rises after an address change.

// File: rtl/otp_rom_port.sv
module otp_rom_port #(
  parameter int ADDR_W = 10,
  parameter int CE_LAT = 3,
  parameter int OE_LAT = 1,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              wide_mode,
  input  logic              id_mode,
  input  logic              half_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [15:0]       prog_data,
  input  logic              erase,
  output logic [15:0]       data_out,
  output logic [1:0]        lane_oe,
  output logic              data_valid,
  output logic              standby
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CE_W  = $clog2(CE_LAT + 1) + 1;
  localparam int OE_W  = $clog2(OE_LAT + 1) + 1;
  localparam int KEY_W = ADDR_W + 3;

  logic [15:0]      mem [WORDS];
  logic [CE_W-1:0]  ce_age;
  logic [OE_W-1:0]  oe_age;
  logic [KEY_W-1:0] key, key_q;
  logic [15:0]      word, sel;
  logic [7:0]       code;

  assign key = {addr, wide_mode ? 1'b0 : half_sel, wide_mode, id_mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (prog_we) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_age <= '0;
      oe_age <= '0;
      key_q  <= '0;
    end else begin
      key_q <= key;
      if (chip_en && key == key_q)
        ce_age <= (ce_age == CE_W'(CE_LAT)) ? ce_age : ce_age + 1'b1;
      else
        ce_age <= '0;
      if (out_en)
        oe_age <= (oe_age == OE_W'(OE_LAT)) ? oe_age : oe_age + 1'b1;
      else
        oe_age <= '0;
    end
  end

  assign word = mem[addr];
  assign code = addr[0] ? DEV_CODE : MFR_CODE;
  assign sel  = id_mode   ? {8'h00, code} :
                wide_mode ? word :
                {8'h00, half_sel ? word[15:8] : word[7:0]};

  assign standby    = !chip_en;
  assign lane_oe    = {chip_en && out_en && wide_mode, chip_en && out_en};
  assign data_valid = chip_en && out_en &&
                      ce_age == CE_W'(CE_LAT) && oe_age == OE_W'(OE_LAT);
  assign data_out   = data_valid ? sel : 16'h0000;
endmodule

// File: rtl/otp_rom_port_chk.sv
module otp_rom_port_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              out_en,
  input logic              wide_mode,
  input logic              id_mode,
  input logic              half_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              erase,
  input logic [15:0]       data_out,
  input logic [1:0]        lane_oe,
  input logic              data_valid,
  input logic              standby
);
  AST_VALID_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(chip_en)); // R8
  AST_VALID_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(out_en)); // R9
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (lane_oe == 2'b00 && standby)); // R4
  AST_DRIVE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe != 2'b00) |-> (chip_en && out_en)); // R3
  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> (!lane_oe[1] && data_out[15:8] == 8'h00)); // R2
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode |-> data_out[15:8] == 8'h00); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> data_out == 16'h0000); // R10
  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid) && $stable(addr) && $stable(wide_mode) &&
     $stable(id_mode) && $stable(half_sel) && !$past(erase))
    |-> ((data_out & ~$past(data_out)) == 16'h0000)); // R6
endmodule

bind otp_rom_port otp_rom_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
  .wide_mode(wide_mode), .id_mode(id_mode), .half_sel(half_sel),
  .addr(addr), .erase(erase), .data_out(data_out), .lane_oe(lane_oe),
  .data_valid(data_valid), .standby(standby)
);

// File: tb/otp_rom_port_tb.sv
module otp_rom_port_tb;
  localparam int AW = 10;
  localparam int CL = 3;
  localparam int OL = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 0, out_en = 0, wide_mode = 1, id_mode = 0, half_sel = 0;
  logic [AW-1:0] addr = '0, prog_addr = '0;
  logic prog_we = 0, erase = 0;
  logic [15:0] prog_data = '0;
  logic [15:0] data_out;
  logic [1:0]  lane_oe;
  logic        data_valid, standby;

  always #2.5 clk = ~clk;

  otp_rom_port #(.ADDR_W(AW), .CE_LAT(CL), .OE_LAT(OL)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
    .wide_mode(wide_mode), .id_mode(id_mode), .half_sel(half_sel),
    .addr(addr), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase(erase), .data_out(data_out),
    .lane_oe(lane_oe), .data_valid(data_valid), .standby(standby)
  );

  int checks = 0, errors = 0;
  string tag = "R4";
  logic [15:0] m_mem [0:(1<<AW)-1];
  int m_ce = 0, m_oe = 0;
  logic [AW+2:0] m_key = '0;

  initial for (int i = 0; i < (1 << AW); i++) m_mem[i] = 16'hFFFF;

  function automatic logic [AW+2:0] cur_key();
    return {addr, wide_mode ? 1'b0 : half_sel, wide_mode, id_mode};
  endfunction

  task automatic tick();
    logic        ev;
    logic [1:0]  el;
    logic [15:0] ed, w;
    @(negedge clk);
    ev = chip_en && out_en && m_ce >= CL && m_oe >= OL;
    el = {chip_en && out_en && wide_mode, chip_en && out_en};
    w  = m_mem[addr];
    if (!ev)            ed = 16'h0000;
    else if (id_mode)   ed = {8'h00, addr[0] ? 8'hB1 : 8'h20};
    else if (wide_mode) ed = w;
    else                ed = {8'h00, half_sel ? w[15:8] : w[7:0]};
    checks++;
    if (data_out !== ed || data_valid !== ev || lane_oe !== el || standby !== !chip_en) begin
      errors++;
      $display("FAIL %s data=%h/%h valid=%b/%b lane=%b/%b stby=%b/%b (actual/expected)",
               tag, data_out, ed, data_valid, ev, lane_oe, el, standby, !chip_en);
    end
    @(posedge clk);
    if (rst_n) begin
      if (erase) for (int i = 0; i < (1 << AW); i++) m_mem[i] = 16'hFFFF;
      else if (prog_we) m_mem[prog_addr] = m_mem[prog_addr] & prog_data;
      m_ce = (chip_en && cur_key() == m_key) ? ((m_ce < CL) ? m_ce + 1 : CL) : 0;
      m_oe = out_en ? ((m_oe < OL) ? m_oe + 1 : OL) : 0;
      m_key = cur_key();
    end
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    tag = "R4"; repeat (3) tick();
    rst_n = 1'b1;
    out_en = 1; repeat (4) tick();

    tag = "R5"; chip_en = 1; addr = 5; repeat (5) tick();

    tag = "R6"; chip_en = 0; prog_we = 1; prog_addr = 5; prog_data = 16'hA5F0; tick();
    prog_data = 16'h0FFF; tick();
    for (int i = 0; i < 16; i++) begin
      prog_addr = AW'(16 + i); prog_data = 16'(i * 16'h1111) ^ 16'h3C3C; tick();
    end
    prog_we = 0;

    tag = "R1"; chip_en = 1; addr = 5; repeat (5) tick();
    addr = 20; repeat (5) tick();

    tag = "R8";
    for (int i = 0; i < 6; i++) begin addr = AW'(16 + i); repeat (2) tick(); end
    repeat (5) tick();

    tag = "R2"; wide_mode = 0; half_sel = 0; repeat (5) tick();
    half_sel = 1; repeat (5) tick();
    addr = 5; half_sel = 0; repeat (5) tick();
    half_sel = 1; repeat (5) tick();

    tag = "R9"; out_en = 0; repeat (2) tick();
    out_en = 1; repeat (3) tick();

    tag = "R3"; out_en = 0; repeat (3) tick();
    out_en = 1; tick();

    tag = "R7"; id_mode = 1; wide_mode = 1; addr = 0; repeat (5) tick();
    addr = 1; repeat (5) tick();
    wide_mode = 0; repeat (5) tick();

    tag = "R10"; id_mode = 0; wide_mode = 1; addr = 5;
    for (int i = 0; i < 4; i++) begin out_en = ~out_en; tick(); end
    out_en = 1; repeat (4) tick();

    tag = "R6"; prog_we = 1; prog_addr = 5; prog_data = 16'hFF7E; repeat (2) tick();
    prog_we = 0; repeat (2) tick();

    tag = "R5"; erase = 1; prog_we = 1; prog_addr = 20; prog_data = 16'h0000; tick();
    erase = 0; prog_we = 0; repeat (4) tick();
    addr = 20; repeat (5) tick();

    tag = "R4"; chip_en = 0; repeat (3) tick();
    finish_run();
  end
endmodule